// File: doc/BRIEF.md
# Dual Interval Timer

This block holds two independent up-counting timers that a processor programs through a narrow auxiliary register bus. Each timer has a counter, a limit and a two-bit control word. On every clock the counter moves up by one. When it has reached the programmed limit, the next step returns it to zero. If interrupts are enabled for that timer, the same step also latches a pending flag that drives a level interrupt.

One timer normally serves as the per-core tick source. The other, given an all-ones limit, runs as a free-running reference that wraps through its whole range. A control bit can make a timer pause while the processor reports that it is halted. Any write to a timer's control word drops its pending interrupt, whatever value is written. Reads are combinational on the address, and addresses that map to no register read as zero.

Top module: `dual_interval_timer`

## Requirements
- R1: Synchronous reset clears every counter, limit and control word and both pending flags, so every register reads zero and `irq` is 0.
- R2: Timer 0 decodes count at 0x21, control at 0x22 and limit at 0x23. Timer 1 decodes count at 0x100, control at 0x101 and limit at 0x102. Every other address reads zero.
- R3: While a timer runs and its count is below its limit, the count rises by exactly one per clock.
- R4: A step taken while the count equals the limit loads zero into the count. With a limit of zero the count stays at zero.
- R5: Control bit 0 enables the interrupt. A wrap step taken while bit 0 is 1 sets the pending flag. A wrap while bit 0 is 0 leaves it clear. `irq[t]` is the pending flag ANDed with bit 0.
- R6: Once raised, `irq[t]` stays high until a control write to that timer. Such a write clears the pending flag whatever data it carries, and it wins over a wrap that happens in the same cycle.
- R7: When control bit 1 is 1 and `halted` is 1, the count holds its value. When bit 1 is 0, `halted` has no effect on counting.
- R8: A write to the count register loads the written value on the next edge. This takes priority over stepping, applies even while the timer is paused, and a wrap coinciding with the load sets no pending flag.
- R9: A write to one timer's registers changes no register and no interrupt of the other timer.
- R10: With the limit set to all ones, the count climbs through the maximum value and then wraps to zero.
- R11: Control reads return bit 0 = interrupt enable and bit 1 = halt gating, with all higher bits zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| halted | input | 1 | High while the processor is halted |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address for reads and writes |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Combinational read data for `addr` |
| irq | output | 2 | Level interrupt, one bit per timer |

## Verification
The bench builds the timer with DATA_W = 8 and keeps the default 12-bit address and the default register addresses. An 8-bit counter makes it practical to sweep every limit from 0 to 255, each through a full wrap with the interrupt raised, while timer 1 wraps through its full range many times in the background. The 12-bit address space is small enough that every unmapped address is read back. Halt gating, count loads during a pause, and a control write that lands on the same edge as a wrap are each driven directly and compared against a cycle model.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int N_TMR     = 2;
  localparam int N_REG     = 3;
  localparam int CTRL_W    = 2;
  localparam int OFS_COUNT = 0;
  localparam int OFS_CTRL  = 1;
  localparam int OFS_LIMIT = 2;

  // bit 1: pause while halted, bit 0: interrupt enable
  typedef struct packed {
    logic halt_gate;
    logic irq_en;
  } tmr_ctrl_t;
endpackage

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              halted,
  input  logic              cnt_we,
  input  logic              ctrl_we,
  input  logic              lim_we,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] cnt_q,
  output logic [DATA_W-1:0] lim_q,
  output tmr_ctrl_t         ctrl_q,
  output logic              irq
);
  logic pend_q;
  logic run;
  logic at_lim;

  assign run    = !(ctrl_q.halt_gate && halted);
  assign at_lim = (cnt_q == lim_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      lim_q  <= '0;
      ctrl_q <= '0;
      pend_q <= 1'b0;
    end else begin
      if (cnt_we)
        cnt_q <= wr_data;
      else if (run)
        cnt_q <= at_lim ? '0 : cnt_q + DATA_W'(1);

      if (lim_we)
        lim_q <= wr_data;

      if (ctrl_we) begin
        ctrl_q <= tmr_ctrl_t'(wr_data[CTRL_W-1:0]);
        pend_q <= 1'b0;
      end else if (run && at_lim && !cnt_we && ctrl_q.irq_en) begin
        pend_q <= 1'b1;
      end
    end
  end

  assign irq = pend_q & ctrl_q.irq_en;
endmodule

// File: rtl/tmr_rd_mux.sv
module tmr_rd_mux #(
  parameter int N_WORD = 6,
  parameter int DATA_W = 32
) (
  input  logic [N_WORD-1:0]        hit,
  input  logic [N_WORD*DATA_W-1:0] words,
  output logic [DATA_W-1:0]        rd_data
);
  always_comb begin
    rd_data = '0;
    for (int i = 0; i < N_WORD; i++)
      if (hit[i]) rd_data = rd_data | words[i*DATA_W +: DATA_W];
  end
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
  import tmr_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 12,
  parameter int T0_BASE = 'h21,
  parameter int T1_BASE = 'h100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              halted,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic [1:0]        irq
);
  localparam int N_WORD = N_TMR * N_REG;

  logic [N_WORD-1:0]        hit;
  logic [N_WORD*DATA_W-1:0] words;

  for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
    localparam logic [ADDR_W-1:0] BASE =
      (g == 0) ? ADDR_W'(T0_BASE) : ADDR_W'(T1_BASE);

    logic [DATA_W-1:0] cnt_q;
    logic [DATA_W-1:0] lim_q;
    tmr_ctrl_t         ctrl_q;
    logic              hit_cnt, hit_ctrl, hit_lim;

    assign hit_cnt  = (addr == BASE + ADDR_W'(OFS_COUNT));
    assign hit_ctrl = (addr == BASE + ADDR_W'(OFS_CTRL));
    assign hit_lim  = (addr == BASE + ADDR_W'(OFS_LIMIT));

    tmr_channel #(.DATA_W(DATA_W)) u_ch (
      .clk     (clk),
      .rst     (rst),
      .halted  (halted),
      .cnt_we  (wr_en && hit_cnt),
      .ctrl_we (wr_en && hit_ctrl),
      .lim_we  (wr_en && hit_lim),
      .wr_data (wr_data),
      .cnt_q   (cnt_q),
      .lim_q   (lim_q),
      .ctrl_q  (ctrl_q),
      .irq     (irq[g])
    );

    assign hit[g*N_REG + OFS_COUNT] = hit_cnt;
    assign hit[g*N_REG + OFS_CTRL]  = hit_ctrl;
    assign hit[g*N_REG + OFS_LIMIT] = hit_lim;
    assign words[(g*N_REG + OFS_COUNT)*DATA_W +: DATA_W] = cnt_q;
    assign words[(g*N_REG + OFS_CTRL)*DATA_W +: DATA_W]  =
      {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
    assign words[(g*N_REG + OFS_LIMIT)*DATA_W +: DATA_W] = lim_q;
  end

  tmr_rd_mux #(.N_WORD(N_WORD), .DATA_W(DATA_W)) u_rd (
    .hit     (hit),
    .words   (words),
    .rd_data (rd_data)
  );
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 12,
  parameter int T0_BASE = 'h21,
  parameter int T1_BASE = 'h100
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] rd_data,
  input logic [1:0]        irq
);
  localparam logic [ADDR_W-1:0] B0 = ADDR_W'(T0_BASE);
  localparam logic [ADDR_W-1:0] B1 = ADDR_W'(T1_BASE);

  logic in_t0, in_t1, ctl0_wr, ctl1_wr;
  assign in_t0   = (addr == B0) || (addr == B0 + 1'b1) || (addr == B0 + 2'd2);
  assign in_t1   = (addr == B1) || (addr == B1 + 1'b1) || (addr == B1 + 2'd2);
  assign ctl0_wr = wr_en && (addr == B0 + 1'b1);
  assign ctl1_wr = wr_en && (addr == B1 + 1'b1);

  // R1
  a_r1_reset_quiet: assert property (@(posedge clk) rst |=> (irq == 2'b00));

  // R2
  a_r2_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (!in_t0 && !in_t1) |-> (rd_data == '0));

  // R6
  a_r6_t0_ctrl_clears: assert property (@(posedge clk) disable iff (rst)
    ctl0_wr |=> !irq[0]);
  a_r6_t1_ctrl_clears: assert property (@(posedge clk) disable iff (rst)
    ctl1_wr |=> !irq[1]);
  a_r6_t0_sticky: assert property (@(posedge clk) disable iff (rst)
    (irq[0] && !ctl0_wr) |=> irq[0]);
  a_r6_t1_sticky: assert property (@(posedge clk) disable iff (rst)
    (irq[1] && !ctl1_wr) |=> irq[1]);

  // R9
  a_r9_t0_spares_t1: assert property (@(posedge clk) disable iff (rst)
    (irq[1] && wr_en && in_t0) |=> irq[1]);
  a_r9_t1_spares_t0: assert property (@(posedge clk) disable iff (rst)
    (irq[0] && wr_en && in_t1) |=> irq[0]);
endmodule

bind dual_interval_timer tmr_checker #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .T0_BASE(T0_BASE), .T1_BASE(T1_BASE)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
  .rd_data(rd_data), .irq(irq)
);

// File: tb/sim_dual_interval_timer.sv
module sim_dual_interval_timer;
  localparam int DW = 8;
  localparam int AW = 12;
  localparam logic [AW-1:0] T0 = 12'h021;
  localparam logic [AW-1:0] T1 = 12'h100;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          halted = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic [1:0]    irq;

  always #10 clk = ~clk;

  dual_interval_timer #(.DATA_W(DW), .ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .halted(halted), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
  );

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [DW-1:0] m_cnt [2];
  logic [DW-1:0] m_lim [2];
  logic          m_ie  [2];
  logic          m_nh  [2];
  logic          m_pend[2];

  function automatic logic [AW-1:0] base(int t);
    return (t == 0) ? T0 : T1;
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int t = 0; t < 2; t++) begin
      m_cnt[t] = '0; m_lim[t] = '0; m_ie[t] = 0; m_nh[t] = 0; m_pend[t] = 0;
    end
  endtask

  // next state from the requirements, applied with the inputs of this cycle
  task automatic model_step();
    for (int t = 0; t < 2; t++) begin
      bit cw = wr_en && addr == base(t);
      bit kw = wr_en && addr == base(t) + 1;
      bit lw = wr_en && addr == base(t) + 2;
      bit go = !(m_nh[t] && halted);
      logic [DW-1:0] nc = m_cnt[t];
      logic np = m_pend[t];
      if (cw) nc = wr_data;
      else if (go) begin
        if (m_cnt[t] == m_lim[t]) begin
          nc = '0;
          if (m_ie[t]) np = 1;
        end else nc = m_cnt[t] + 1;
      end
      if (kw) begin
        m_ie[t] = wr_data[0]; m_nh[t] = wr_data[1]; np = 0;
      end
      if (lw) m_lim[t] = wr_data;
      m_cnt[t] = nc; m_pend[t] = np;
    end
  endtask

  task automatic cyc();
    model_step();
    @(posedge clk); #1;
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    cyc();
    wr_en = 1'b0; addr = '0;
  endtask

  task automatic chk_all(string req);
    for (int t = 0; t < 2; t++) begin
      addr = base(t);     #1; check(req, "count", rd_data, m_cnt[t]);
      addr = base(t) + 1; #1; check(req, "control", rd_data, {m_nh[t], m_ie[t]});
      addr = base(t) + 2; #1; check(req, "limit", rd_data, m_lim[t]);
      check(req, "irq", irq[t], m_pend[t] & m_ie[t]);
    end
    addr = '0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    model_clear();
    rst = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    chk_all("R1");
    cyc(); chk_all("R1 R4 zero limit");

    // R2: every unmapped address reads zero
    begin
      int bad = 0;
      for (int a = 0; a < (1 << AW); a++) begin
        bit mapped = (a >= 'h21 && a <= 'h23) || (a >= 'h100 && a <= 'h102);
        if (!mapped) begin
          addr = AW'(a); #1;
          if (rd_data !== '0) bad++;
        end
      end
      addr = '0;
      check("R2", "unmapped nonzero reads", bad, 0);
    end

    // R2 R11: map distinct values into each register
    wr(T0 + 2, 8'h3C); chk_all("R2");
    wr(T1 + 2, 8'hA5); chk_all("R2");
    wr(T0 + 1, 8'hFE); chk_all("R11 control read bit1 only");
    wr(T1 + 1, 8'hFD); chk_all("R11 control read bit0 only");
    wr(T0, 8'h10);     chk_all("R2 R8");
    wr(T1, 8'h20);     chk_all("R2 R8");

    do_reset();
    // timer 1 as free-running reference
    wr(T1 + 2, 8'hFF); wr(T1, 8'h00); wr(T1 + 1, 8'h00);

    // R3 R4 R5 R10: every limit through a wrap with interrupt enabled
    for (int lim = 0; lim < 256; lim++) begin
      wr(T0 + 2, DW'(lim));
      wr(T0 + 1, 8'h01);
      wr(T0, 8'h00);
      chk_all("R8 R3");
      for (int k = 0; k < lim + 2; k++) begin
        cyc(); chk_all("R3 R4 R5 R10");
      end
    end

    // R5: wrap without interrupt enable
    wr(T0 + 1, 8'h00); wr(T0 + 2, 8'h04); wr(T0, 8'h00);
    repeat (12) begin cyc(); chk_all("R5 disabled"); end

    // R6: raise, hold, clear with any data
    wr(T0 + 1, 8'h01); wr(T0, 8'h00);
    repeat (6) begin cyc(); chk_all("R6 raise"); end
    check("R6", "irq0 raised", irq[0], 1'b1);
    repeat (5) begin cyc(); chk_all("R6 hold"); end
    wr(T0 + 1, 8'h01); chk_all("R6 clear value 1");
    check("R6", "irq0 after clear", irq[0], 1'b0);
    repeat (6) cyc();
    wr(T0 + 1, 8'h00); chk_all("R6 clear value 0");
    // control write on the same edge as a wrap
    wr(T0 + 1, 8'h01); wr(T0, 8'h04);
    wr(T0 + 1, 8'h01); chk_all("R6 coincident wrap");
    check("R6", "irq0 after coincident", irq[0], 1'b0);
    // count load on the same edge as a wrap
    wr(T0, 8'h04); wr(T0, 8'h02); chk_all("R8 load over wrap");

    // R7: halt gating
    wr(T0 + 2, 8'hFF); wr(T0 + 1, 8'h02); wr(T0, 8'h00);
    halted = 1'b1;
    repeat (10) begin cyc(); chk_all("R7 paused"); end
    wr(T0, 8'h33); chk_all("R8 load while paused");
    repeat (3) begin cyc(); chk_all("R7 paused"); end
    halted = 1'b0;
    repeat (5) begin cyc(); chk_all("R7 resumed"); end
    wr(T0 + 1, 8'h00);
    halted = 1'b1;
    repeat (5) begin cyc(); chk_all("R7 gating off"); end
    halted = 1'b0;

    // R8: direct loads mid-count
    wr(T0, 8'h80); chk_all("R8");
    wr(T0, 8'h7F); chk_all("R8");
    cyc(); chk_all("R8 R3");

    // R9: timer 0 writes leave timer 1 interrupt alone
    wr(T1 + 2, 8'h03); wr(T1 + 1, 8'h01); wr(T1, 8'h00);
    repeat (5) cyc();
    check("R9", "irq1 raised", irq[1], 1'b1);
    wr(T0 + 1, 8'h03); chk_all("R9");
    wr(T0, 8'h11);     chk_all("R9");
    wr(T0 + 2, 8'h22); chk_all("R9");
    check("R9", "irq1 kept", irq[1], 1'b1);

    // R10: full range wrap
    wr(T0 + 2, 8'hFF); wr(T0 + 1, 8'h00); wr(T0, 8'hFD);
    repeat (3) begin cyc(); chk_all("R10"); end
    check("R10", "count after max", m_cnt[0], 8'h00);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule